// File: doc/BRIEF.md
# PME Root Status Tracker

This block keeps the status word that a PCI Express root port shows for power management event (PME) messages coming from devices below it. Each PME arrives as a one-cycle strobe carrying a 16-bit requester ID. The block shows a 32-bit word. The word holds a status flag, a pending flag and the requester ID of the PME being reported. Software clears the status flag by writing a 1 to it through a register write port.

When a PME arrives while an earlier one is still being reported, the new PME is not lost. It goes into a small first-in first-out queue, and the pending flag rises. Each time software clears the status flag, the oldest queued PME is handed over on the following clock edge. The status flag is then set again with that PME's ID. When the queue is full, further arrivals are dropped, and a one-cycle overflow pulse flags each drop.

Top module: `pme_root_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, `status_word` reads 0x00000000, `pme_overflow` is 0 and the queue is empty.
- R2: Bits 31:18 of `status_word` always read 0. A write of ones to them with every byte lane enabled changes nothing in the word.
- R3: The status flag is bit 16. A write with `cfg_wr_en`=1, `cfg_byte_en[2]`=1 and `cfg_wr_data[16]`=1 clears it on that clock edge. A write with data bit 16 at 0, or with `cfg_byte_en[2]`=0, leaves the word unchanged.
- R4: When the status flag is 0 and the queue is empty, a PME strobe sets the status flag on that clock edge and loads bits 15:0 with its requester ID.
- R5: While the status flag is 1, a PME strobe without a clearing write leaves the status flag and bits 15:0 unchanged. The PME is queued, and the pending flag (bit 17) reads 1 after that edge.
- R6: After a clearing write while PMEs wait, the word reads status 0 and pending 1 for one cycle. On the next edge the status flag is set again with the oldest waiting requester ID, so queued PMEs are delivered oldest first.
- R7: The pending flag reads 0 once the last waiting PME has been moved into bits 15:0.
- R8: The queue holds at most 4 waiting PMEs. A PME arriving while 4 wait, with no delivery on that edge, is dropped and never reported. `pme_overflow` reads 1 for exactly the one cycle after that edge.
- R9: A PME arriving in the same cycle as a clearing write, with no PME waiting, is reported at once: the status flag stays 1, bits 15:0 take its ID and the pending flag stays 0.
- R10: Bits 17 and 15:0 are read-only. Writes of any data to them leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pme_valid | input | 1 | One-cycle strobe: a PME message has arrived |
| pme_req_id | input | 16 | Requester ID of the arriving PME |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_byte_en | input | 4 | Byte lane enables of the write |
| cfg_wr_data | input | 32 | Write data |
| status_word | output | 32 | Read view: bit 17 pending, bit 16 status, bits 15:0 requester ID |
| pme_overflow | output | 1 | One-cycle pulse after a PME was dropped on a full queue |

## Verification
The assertions assume that `pme_valid` is a clean single-cycle strobe. They also assume that a clearing write is a single cycle with stable data, so that each strobe stands for exactly one PME. The stimulus drives every input just after a rising edge and holds it for one whole cycle. Each input goes back to idle unless the next step asks for another event, so no event is counted twice. The stimulus never holds reset low in the middle of a property window except in the reset test. That test checks only the reset outputs and does not check sequencing.

// File: rtl/pme_tracker_pkg.sv
package pme_tracker_pkg;

  localparam int ID_W     = 16;
  localparam int WORD_W   = 32;
  localparam int STAT_BIT = 16;
  localparam int PEND_BIT = 17;
  localparam int STAT_LANE = STAT_BIT / 8;

  typedef logic [ID_W-1:0]   req_id_t;
  typedef logic [WORD_W-1:0] word_t;

  // A clearing access: lane holding the status bit enabled and a 1 written to it
  function automatic logic status_clear_hit(input logic wr_en,
                                            input logic [WORD_W/8-1:0] be,
                                            input word_t wdata);
    return wr_en & be[STAT_LANE] & wdata[STAT_BIT];
  endfunction

  // Assemble the read view; everything above the pending bit is zero
  function automatic word_t pack_word(input logic pending,
                                      input logic status,
                                      input req_id_t id);
    word_t w;
    w = '0;
    w[ID_W-1:0] = id;
    w[STAT_BIT] = status;
    w[PEND_BIT] = pending;
    return w;
  endfunction

endpackage

// File: rtl/pme_fifo.sv
module pme_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   mem[g] <= '0;
      else if (do_push && wr_ptr == PTR_W'(g))      mem[g] <= din;
    end
  end

endmodule

// File: rtl/pme_cfg_decode.sv
module pme_cfg_decode
  import pme_tracker_pkg::*;
(
  input  logic                cfg_wr_en,
  input  logic [WORD_W/8-1:0] cfg_byte_en,
  input  word_t               cfg_wr_data,
  output logic                clear_evt
);
  assign clear_evt = status_clear_hit(cfg_wr_en, cfg_byte_en, cfg_wr_data);
endmodule

// File: rtl/pme_report_ctrl.sv
module pme_report_ctrl
  import pme_tracker_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clear_evt,
  input  logic    pme_valid,
  input  req_id_t pme_req_id,
  input  logic    q_empty,
  input  logic    q_full,
  input  req_id_t q_head,
  output logic    q_push,
  output logic    q_pop,
  output logic    drop_evt,
  output logic    status_q,
  output req_id_t id_q,
  output logic    ovf_q
);
  logic    status_d;
  req_id_t id_d;

  always_comb begin
    status_d = status_q;
    id_d     = id_q;
    q_push   = 1'b0;
    q_pop    = 1'b0;
    drop_evt = 1'b0;
    if (!status_q) begin
      if (!q_empty) begin
        // redelivery of the oldest waiting PME; a new arrival queues behind it
        q_pop    = 1'b1;
        status_d = 1'b1;
        id_d     = q_head;
        q_push   = pme_valid;
      end else if (pme_valid) begin
        status_d = 1'b1;
        id_d     = pme_req_id;
      end
    end else if (clear_evt) begin
      if (q_empty && pme_valid) begin
        id_d = pme_req_id;
      end else begin
        status_d = 1'b0;
        if (pme_valid) begin
          q_push   = ~q_full;
          drop_evt = q_full;
        end
      end
    end else if (pme_valid) begin
      q_push   = ~q_full;
      drop_evt = q_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      id_q     <= '0;
      ovf_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      id_q     <= id_d;
      ovf_q    <= drop_evt;
    end
  end
endmodule

// File: rtl/pme_root_tracker.sv
module pme_root_tracker
  import pme_tracker_pkg::*;
#(
  parameter int QUEUE_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pme_valid,
  input  logic [15:0] pme_req_id,
  input  logic        cfg_wr_en,
  input  logic [3:0]  cfg_byte_en,
  input  logic [31:0] cfg_wr_data,
  output logic [31:0] status_word,
  output logic        pme_overflow
);
  logic    clear_evt, drop_evt;
  logic    q_push, q_pop, q_empty, q_full;
  req_id_t q_head, id_q;
  logic    status_q;

  pme_cfg_decode u_dec (
    .cfg_wr_en   (cfg_wr_en),
    .cfg_byte_en (cfg_byte_en),
    .cfg_wr_data (cfg_wr_data),
    .clear_evt   (clear_evt)
  );

  pme_fifo #(.W(ID_W), .DEPTH(QUEUE_DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .pop   (q_pop),
    .din   (pme_req_id),
    .dout  (q_head),
    .empty (q_empty),
    .full  (q_full)
  );

  pme_report_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_evt  (clear_evt),
    .pme_valid  (pme_valid),
    .pme_req_id (pme_req_id),
    .q_empty    (q_empty),
    .q_full     (q_full),
    .q_head     (q_head),
    .q_push     (q_push),
    .q_pop      (q_pop),
    .drop_evt   (drop_evt),
    .status_q   (status_q),
    .id_q       (id_q),
    .ovf_q      (pme_overflow)
  );

  assign status_word = pack_word(~q_empty, status_q, id_q);

endmodule

// File: rtl/pme_root_tracker_chk.sv
module pme_root_tracker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pme_valid,
  input logic [15:0] pme_req_id,
  input logic        clear_evt,
  input logic        drop_evt,
  input logic [31:0] status_word,
  input logic        pme_overflow
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[31:18] == '0);                                                   // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_evt && status_word[16] && !pme_valid) |=> !status_word[16]);          // R3

  AST_REPORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[16] && !clear_evt) |=> (status_word[16] && $stable(status_word[15:0]))); // R5

  AST_REDELIVER: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[17] && !status_word[16]) |=> status_word[16]);                  // R6

  AST_DIRECT_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_evt && pme_valid && status_word[16] && !status_word[17])
      |=> (status_word[16] && !status_word[17] && status_word[15:0] == $past(pme_req_id))); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pme_overflow |-> status_word[17]);                                            // R8

  AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> pme_overflow);                                                   // R8
endmodule

bind pme_root_tracker pme_root_tracker_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pme_valid    (pme_valid),
  .pme_req_id   (pme_req_id),
  .clear_evt    (clear_evt),
  .drop_evt     (drop_evt),
  .status_word  (status_word),
  .pme_overflow (pme_overflow)
);

// File: tb/pme_root_tracker_bench.sv
module pme_root_tracker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pme_valid = 1'b0;
  logic [15:0] pme_req_id = '0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_byte_en = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] status_word;
  logic        pme_overflow;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pme_root_tracker u_pme_root_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .pme_valid    (pme_valid),
    .pme_req_id   (pme_req_id),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_byte_en  (cfg_byte_en),
    .cfg_wr_data  (cfg_wr_data),
    .status_word  (status_word),
    .pme_overflow (pme_overflow)
  );

  typedef struct packed {
    logic        pv;
    logic [15:0] id;
    logic        wr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp_word;
    logic        exp_ovf;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h1111, 1'b0, 4'h0, 32'h0,          32'h0001_1111, 1'b0, 8'd4},  // R4 first PME
    '{1'b1, 16'h2222, 1'b0, 4'h0, 32'h0,          32'h0003_1111, 1'b0, 8'd5},  // R5 queued
    '{1'b0, 16'h0,    1'b1, 4'h4, 32'h0,          32'h0003_1111, 1'b0, 8'd3},  // R3 zero write
    '{1'b0, 16'h0,    1'b1, 4'hB, 32'hFFFF_FFFF,  32'h0003_1111, 1'b0, 8'd10}, // R10 lane 2 off
    '{1'b0, 16'h0,    1'b1, 4'h4, 32'h0001_0000,  32'h0002_1111, 1'b0, 8'd3},  // R3 clear
    '{1'b0, 16'h0,    1'b0, 4'h0, 32'h0,          32'h0001_2222, 1'b0, 8'd6},  // R6 redeliver
    '{1'b1, 16'h3333, 1'b0, 4'h0, 32'h0,          32'h0003_2222, 1'b0, 8'd5},
    '{1'b1, 16'h4444, 1'b0, 4'h0, 32'h0,          32'h0003_2222, 1'b0, 8'd5},
    '{1'b1, 16'h5555, 1'b0, 4'h0, 32'h0,          32'h0003_2222, 1'b0, 8'd5},
    '{1'b1, 16'h6666, 1'b0, 4'h0, 32'h0,          32'h0003_2222, 1'b0, 8'd8},  // R8 queue full
    '{1'b1, 16'h7777, 1'b0, 4'h0, 32'h0,          32'h0003_2222, 1'b1, 8'd8},  // R8 dropped
    '{1'b0, 16'h0,    1'b0, 4'h0, 32'h0,          32'h0003_2222, 1'b0, 8'd8},  // R8 one cycle
    '{1'b0, 16'h0,    1'b1, 4'hF, 32'hFFFF_FFFF,  32'h0002_2222, 1'b0, 8'd2},  // R2 reserved ignored
    '{1'b0, 16'h0,    1'b0, 4'h0, 32'h0,          32'h0003_3333, 1'b0, 8'd6},
    '{1'b1, 16'h8888, 1'b1, 4'h4, 32'h0001_0000,  32'h0002_3333, 1'b0, 8'd6},  // R6 clear + arrival
    '{1'b0, 16'h0,    1'b0, 4'h0, 32'h0,          32'h0003_4444, 1'b0, 8'd6},
    '{1'b0, 16'h0,    1'b1, 4'h4, 32'h0001_0000,  32'h0002_4444, 1'b0, 8'd6},
    '{1'b0, 16'h0,    1'b0, 4'h0, 32'h0,          32'h0003_5555, 1'b0, 8'd6},
    '{1'b0, 16'h0,    1'b1, 4'h4, 32'h0001_0000,  32'h0002_5555, 1'b0, 8'd6},
    '{1'b0, 16'h0,    1'b0, 4'h0, 32'h0,          32'h0003_6666, 1'b0, 8'd6},
    '{1'b0, 16'h0,    1'b1, 4'h4, 32'h0001_0000,  32'h0002_6666, 1'b0, 8'd6},
    '{1'b0, 16'h0,    1'b0, 4'h0, 32'h0,          32'h0001_8888, 1'b0, 8'd7},  // R7 last one
    '{1'b1, 16'h9999, 1'b1, 4'h4, 32'h0001_0000,  32'h0001_9999, 1'b0, 8'd9},  // R9 direct
    '{1'b0, 16'h0,    1'b1, 4'h4, 32'h0003_FFFF,  32'h0000_9999, 1'b0, 8'd10}, // R10 ro fields
    '{1'b0, 16'h0,    1'b0, 4'h0, 32'h0,          32'h0000_9999, 1'b0, 8'd3},
    '{1'b1, 16'hABCD, 1'b0, 4'h0, 32'h0,          32'h0001_ABCD, 1'b0, 8'd4}
  };

  task automatic check(input string tag, input logic [31:0] got_w, input logic got_o,
                       input logic [31:0] exp_w, input logic exp_o);
    n_vec++;
    if (got_w !== exp_w || got_o !== exp_o) begin
      n_fail++;
      $display("FAIL %s: word=%h ovf=%b expected word=%h ovf=%b", tag, got_w, got_o, exp_w, exp_o);
    end
  endtask

  task automatic idle_inputs();
    pme_valid = 1'b0; pme_req_id = '0;
    cfg_wr_en = 1'b0; cfg_byte_en = '0; cfg_wr_data = '0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    idle_inputs();
    #5;
    check("R1 in reset", status_word, pme_overflow, 32'h0, 1'b0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", status_word, pme_overflow, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      pme_valid   = VEC[i].pv;
      pme_req_id  = VEC[i].id;
      cfg_wr_en   = VEC[i].wr;
      cfg_byte_en = VEC[i].be;
      cfg_wr_data = VEC[i].wd;
      @(posedge clk); #1;
      idle_inputs();
      check($sformatf("R%0d row %0d", VEC[i].req, i), status_word, pme_overflow,
            VEC[i].exp_word, VEC[i].exp_ovf);
    end

    // R1: reset in the middle of a loaded queue
    for (int k = 0; k < 3; k++) begin
      pme_valid = 1'b1; pme_req_id = 16'h0C00 + 16'(k);
      @(posedge clk); #1;
    end
    idle_inputs();
    check("R5 loaded before reset", status_word, pme_overflow, 32'h0003_ABCD, 1'b0);
    rst_n = 1'b0;
    #2;
    check("R1 mid-run reset", status_word, pme_overflow, 32'h0, 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 queue emptied", status_word, pme_overflow, 32'h0, 1'b0);

    // R7: single queued entry, clear, redeliver, pending drops
    pme_valid = 1'b1; pme_req_id = 16'h00A1; @(posedge clk); #1;
    pme_req_id = 16'h00A2; @(posedge clk); #1;
    idle_inputs();
    cfg_wr_en = 1'b1; cfg_byte_en = 4'h4; cfg_wr_data = 32'h0001_0000;
    @(posedge clk); #1;
    idle_inputs();
    check("R6 gap cycle", status_word, pme_overflow, 32'h0002_00A1, 1'b0);
    @(posedge clk); #1;
    check("R7 pending cleared", status_word, pme_overflow, 32'h0001_00A2, 1'b0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

endmodule